// File: doc/BRIEF.md
# Cascaded Edge-Latching Interrupt Aggregator

This block merges a set of peripheral interrupt requests into one interrupt line toward a host processor. The requests are arranged in byte-wide groups. Each group has a status byte and an enable byte. A simple byte register port gives the host access to them. Every request is first synchronised to the block clock. Most requests are edge-sensitive: a rising edge sets a sticky status bit, and that bit clears when the host reads the status byte holding it. One request, chosen by a parameter, is level-sensitive. Its status bit always shows the synchronised request level.

The host line `irq_o` is a registered OR over every status bit whose enable bit is set. It drops as soon as nothing enabled is pending. This lets an edge-detecting host input see a new rising edge for the next event. An edge that arrives while its enable bit is clear is still recorded, so it can be serviced after the host enables it.

Top module: `irq_cascade`

## Requirements
- R1: After reset every enable byte reads 0, `irq_o` is low and `rdata_o` is 0.
- R2: Two synchroniser stages sit on each request. A request held high from just before clock edge k sets its edge-sensitive status bit after edge k+2.
- R3: Reading a status byte returns that byte's value from before the read. The same read clears the edge-sensitive bits of that group only. `rdata_o` is updated on the edge that samples `rd_en_i` and keeps its value while no read is made.
- R4: If an edge is detected on the same cycle as a read that would clear its bit, the bit stays set.
- R5: The status bit at index `LEVEL_IDX` (default 0) shows the synchronised level of its request. A read never clears it.
- R6: An enable bit of 1 lets its status bit drive the output. `irq_o` is registered from the current status and enable values, one cycle after a status change.
- R7: Edges on requests whose enable bit is clear are still latched. Setting the enable bit later raises `irq_o`.
- R8: `addr_i[2]` = 0 selects status and 1 selects enable. `addr_i[1:0]` picks group g, which covers request bits 8g..8g+7 for g in 0..2. Group 3 reads 0 and ignores writes.
- R9: Writing an enable address replaces that enable byte, and the new value reads back. Writes to status addresses change nothing.
- R10: `irq_o` falls one cycle after the enabled pending set becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 24 | Peripheral interrupt requests, asynchronous |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select: bit 2 picks status or enable, bits 1:0 pick the group |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Aggregated interrupt to the host |

## Verification
A status bit that is wrongly kept or lost shows at the ports in two ways. It changes the next status read of its group. If its enable bit is set, it also moves `irq_o` one cycle after the fault. A corrupted enable byte shows on its next read-back, and `irq_o` shows it at once for any pending bit it covers. The bench keeps a behavioural model and compares `irq_o` and `rdata_o` with it on every clock. Because of this, a wrong sticky bit, a missed collision edge or a stray clear is caught within a cycle or two of the read or edge that exposes it.

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int NUM_GROUPS = 3,
  parameter int GRP_W      = 8,
  parameter int LEVEL_IDX  = 0,
  parameter int GSEL_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GROUPS*GRP_W-1:0]    req_i,
  input  logic                           rd_en_i,
  input  logic                           wr_en_i,
  input  logic [GSEL_W:0]                addr_i,
  input  logic [GRP_W-1:0]               wdata_i,
  output logic [GRP_W-1:0]               rdata_o,
  output logic                           irq_o
);
  localparam int N = NUM_GROUPS * GRP_W;
  localparam logic [N-1:0] EDGE_BITS = ~({{(N-1){1'b0}}, 1'b1} << LEVEL_IDX);

  logic [N-1:0] s1, s2, s3, st_q, mask_q, clr, rise, view;
  logic [GRP_W-1:0] rd_val;
  logic [GSEL_W-1:0] gsel;
  logic is_mask;

  assign gsel    = addr_i[GSEL_W-1:0];
  assign is_mask = addr_i[GSEL_W];
  assign rise    = s2 & ~s3 & EDGE_BITS;
  assign view    = (st_q & EDGE_BITS) | (s2 & ~EDGE_BITS);

  always_comb begin
    clr    = '0;
    rd_val = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (gsel == GSEL_W'(g)) begin
        rd_val = is_mask ? mask_q[g*GRP_W +: GRP_W] : view[g*GRP_W +: GRP_W];
        if (rd_en_i && !is_mask) clr[g*GRP_W +: GRP_W] = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      st_q    <= '0;
      mask_q  <= '0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      s1    <= req_i;
      s2    <= s1;
      s3    <= s2;
      st_q  <= ((st_q & ~clr) | rise) & EDGE_BITS;
      irq_o <= |(view & mask_q);
      if (rd_en_i) rdata_o <= rd_val;
      for (int g = 0; g < NUM_GROUPS; g++)
        if (wr_en_i && is_mask && gsel == GSEL_W'(g))
          mask_q[g*GRP_W +: GRP_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int NUM_GROUPS = 3,
  parameter int GRP_W      = 8,
  parameter int LEVEL_IDX  = 0,
  parameter int GSEL_W     = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en_i,
  input logic                        wr_en_i,
  input logic [GSEL_W:0]             addr_i,
  input logic [GRP_W-1:0]            rdata_o,
  input logic                        irq_o,
  input logic [NUM_GROUPS*GRP_W-1:0] mask_q,
  input logic [NUM_GROUPS*GRP_W-1:0] st_q,
  input logic [NUM_GROUPS*GRP_W-1:0] rise
);
  a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_o);

  a_r4_edge_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((st_q & $past(rise)) == $past(rise)));

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i[GSEL_W]) |=> $stable(mask_q));

  a_r8_bad_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && int'(addr_i[GSEL_W-1:0]) >= NUM_GROUPS) |=> (rdata_o == '0));

  a_r5_level_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[LEVEL_IDX] == 1'b0);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !addr_i[GSEL_W] && addr_i[GSEL_W-1:0] == '0 && rise[GRP_W-1:0] == '0)
      |=> (st_q[GRP_W-1:0] == '0));
endmodule

bind irq_cascade irq_cascade_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .LEVEL_IDX(LEVEL_IDX), .GSEL_W(GSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .mask_q(mask_q), .st_q(st_q), .rise(rise)
);

// File: tb/sim_irq_cascade.sv
`timescale 1ns/1ps
module sim_irq_cascade;
  localparam int LVL = 0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] req = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  irq_cascade u0 (.clk(clk), .rst_n(rst_n), .req_i(req), .rd_en_i(rd), .wr_en_i(wr),
                  .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // behavioural reference model
  bit [23:0] hist[$];
  bit [23:0] m_st, m_mask, cur, prv, vw;
  bit [7:0]  m_rd;
  bit        m_irq;
  int        grp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{24'h0, 24'h0, 24'h0};
      m_st = 0; m_mask = 0; m_rd = 0; m_irq = 0;
    end else begin
      cur = hist[1]; prv = hist[2];
      vw = m_st; vw[LVL] = cur[LVL];
      grp = int'(addr[1:0]);
      if (rd) m_rd = (grp < 3) ? (addr[2] ? m_mask[grp*8 +: 8] : vw[grp*8 +: 8]) : 8'h0;
      m_irq = |(vw & m_mask);
      for (int i = 0; i < 24; i++) begin
        if (i != LVL) begin
          if (rd && !addr[2] && grp == i / 8) m_st[i] = 1'b0;
          if (cur[i] && !prv[i]) m_st[i] = 1'b1;
        end
      end
      if (wr && addr[2] && grp < 3) m_mask[grp*8 +: 8] = wdata;
      hist.push_front(req);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({tag, " irq_o"}, {31'd0, irq}, {31'd0, m_irq});
    chk({tag, " rdata_o"}, {24'd0, rdata}, {24'd0, m_rd});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdchk(logic [2:0] a, logic [7:0] exp, string t);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(t, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic wrreg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 irq after reset", {31'd0, irq}, 0);
    chk("R1 rdata after reset", {24'd0, rdata}, 0);
    rdchk(3'd4, 8'h00, "R1 mask0"); rdchk(3'd5, 8'h00, "R1 mask1"); rdchk(3'd6, 8'h00, "R1 mask2");

    tag = "R7";
    req[3] = 1'b1; idle(4);
    chk("R7 masked edge no irq", {31'd0, irq}, 0);
    tag = "R2"; rdchk(3'd0, 8'h08, "R2 edge latched");
    tag = "R3"; rdchk(3'd0, 8'h00, "R3 read cleared");
    req[3] = 1'b0; idle(3); req[3] = 1'b1; idle(4);
    tag = "R7"; wrreg(3'd4, 8'h08); idle(1);
    chk("R7 unmask raises irq", {31'd0, irq}, 1);
    tag = "R10"; rdchk(3'd0, 8'h08, "R10 pre-clear read"); idle(1);
    chk("R10 irq falls when empty", {31'd0, irq}, 0);

    tag = "R5";
    req[0] = 1'b1; wrreg(3'd4, 8'h01); idle(3);
    rdchk(3'd0, 8'h01, "R5 level seen"); rdchk(3'd0, 8'h01, "R5 level not cleared");
    chk("R6 level enabled irq", {31'd0, irq}, 1);
    req[0] = 1'b0; idle(4);
    chk("R5 level drop clears irq", {31'd0, irq}, 0);

    tag = "R8";
    req[10] = 1'b1; req[17] = 1'b1; idle(4);
    rdchk(3'd0, 8'h00, "R8 group0 unaffected");
    rdchk(3'd1, 8'h04, "R8 group1 bit10");
    rdchk(3'd2, 8'h02, "R3 group2 kept after other reads");
    wrreg(3'd3, 8'hFF); wrreg(3'd7, 8'hFF);
    rdchk(3'd7, 8'h00, "R8 group3 mask reads zero");
    rdchk(3'd3, 8'h00, "R8 group3 status reads zero");
    tag = "R9";
    wrreg(3'd1, 8'hFF); rdchk(3'd5, 8'h00, "R9 status write ignored");
    wrreg(3'd5, 8'hA5); rdchk(3'd5, 8'hA5, "R9 mask readback");
    wrreg(3'd5, 8'h00);

    tag = "R4";
    req[5] = 1'b1; idle(3); req[5] = 1'b0; idle(3);
    @(negedge clk); req[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); rd = 1'b1; addr = 3'd0;
    @(negedge clk); rd = 1'b0;
    chk("R4 read returns old bit", {24'd0, rdata}, 32'h20);
    rdchk(3'd0, 8'h20, "R4 collision edge kept");
    rdchk(3'd0, 8'h00, "R4 then cleared");

    tag = "R6";
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      req   = req ^ ($urandom & $urandom & 24'hFFFFFF);
      rd    = ($urandom % 4) == 0;
      wr    = ($urandom % 6) == 0;
      addr  = 3'($urandom);
      wdata = 8'($urandom);
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule